// File: doc/BRIEF.md
# Panel Init and Frame Flush Sequencer

This controller brings up a 128x64 monochrome panel and repaints it on demand. It sits between a page-organised frame memory and a byte-wide SPI transmitter. It drives the panel's reset, data/command select and chip-select pins directly. After reset it holds the panel reset line low for a programmable number of milliseconds, releases it, and waits the same time again. It then sends a fixed list of 25 configuration command bytes.

Once configured, the block waits for repaint requests. A request makes it send the column-window and page-window commands. It then sends every frame byte as pixel data in a single burst. The frame memory is read through a plain address/data port with one cycle of read latency. The SPI shifter is external and is driven through a start/busy handshake.

The delay length comes from a cycles-per-millisecond parameter, so a short setting can be used in simulation.

Top module: `panel_refresh_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pnl_rst_n` is low, `pnl_cs_n` is high, and `spi_start` and `flush_done` are low.
- R2: After `rst` falls, `pnl_rst_n` stays low for CYC_PER_MS*RST_MS cycles (to within two cycles) and then goes high. The first chip-select assertion follows at least CYC_PER_MS*RST_MS cycles later.
- R3: A byte is handed over by holding `spi_start` high for exactly one cycle, with `spi_byte` valid. The shifter must raise `spi_busy` by the following cycle and hold it until the byte is out. No new `spi_start` is issued while `spi_busy` is high.
- R4: The configuration list is sent with `pnl_dc` low, as these hex bytes in this order: AE D5 80 A8 3F D3 00 40 8D 14 20 00 A1 C8 DA 12 81 CF D9 F1 DB 40 A4 A6 AF. The A8 operand is PAGES*8-1.
- R5: Every command byte has its own chip-select frame. `pnl_cs_n` falls before the byte and rises after it, with at least one high cycle between commands.
- R6: A flush sends six command bytes, each with `pnl_dc` low and in its own frame: 21 00 7F 22 00 07 (the last values are COLS-1 and PAGES-1). It then sends COLS*PAGES data bytes with `pnl_dc` high, all under one chip-select assertion.
- R7: The data bytes come from frame addresses 0 to COLS*PAGES-1 in ascending order, where address = page*COLS + column and bit 0 of each byte is the top row of its page. Each byte sent equals the memory content at its address, given a read latency of one cycle.
- R8: After the last data byte completes and `pnl_cs_n` is high again, `flush_done` pulses for exactly one cycle, once per flush.
- R9: A flush request that arrives while reset or configuration is in progress is held and served once configuration ends.
- R10: Any number of requests that arrive during a flush produce exactly one further flush after it.
- R11: With no request pending, the block issues no SPI transfer and no chip-select assertion while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req | input | 1 | One-cycle request to repaint the panel |
| spi_busy | input | 1 | Shifter is transmitting a byte |
| mem_rdata | input | 8 | Frame memory read data, one cycle after address |
| spi_start | output | 1 | One-cycle pulse handing `spi_byte` to the shifter |
| spi_byte | output | 8 | Byte to transmit |
| mem_addr | output | $clog2(COLS*PAGES) | Frame memory read address |
| pnl_rst_n | output | 1 | Panel reset, active low |
| pnl_dc | output | 1 | Panel data/command select, high for pixel data |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |

## Verification
The bench issues a repaint request during the reset delay. A sequencer that dropped that request would go idle after configuration and never repaint. It counts chip-select falling edges to tell per-command framing from a single burst frame. Merging commands into one frame, or splitting the pixel stream, changes that count away from seven per flush. It compares every pixel byte against the memory pattern at its address, which catches an off-by-one read latency or a skipped last address. Several requests during one flush must give exactly two flushes in total, so both a lost request and a doubled one are visible.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [3:0] {
    S_RLOW, S_RWAIT, S_CSEL, S_CHOLD, S_CWAIT, S_IDLE,
    S_DOPEN, S_DRD, S_DGO, S_DHOLD, S_DWAIT, S_FIN
  } seq_state_t;
  localparam int INIT_LEN = 25;
  localparam int WIN_LEN  = 6;
endpackage

// File: rtl/prc_ms_timer.sv
module prc_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MS         = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int LIM = CYC_PER_MS * MS;
  localparam int TW  = $clog2(LIM + 1);
  logic [TW-1:0] cnt;

  assign expired = en && (cnt == TW'(LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || expired) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prc_cmd_rom.sv
module prc_cmd_rom #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  parameter int IW    = 5
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    code
);
  always_comb begin
    case (idx)
      IW'(0):  code = 8'hAE;
      IW'(1):  code = 8'hD5;
      IW'(2):  code = 8'h80;
      IW'(3):  code = 8'hA8;
      IW'(4):  code = 8'(PAGES * 8 - 1);
      IW'(5):  code = 8'hD3;
      IW'(6):  code = 8'h00;
      IW'(7):  code = 8'h40;
      IW'(8):  code = 8'h8D;
      IW'(9):  code = 8'h14;
      IW'(10): code = 8'h20;
      IW'(11): code = 8'h00;
      IW'(12): code = 8'hA1;
      IW'(13): code = 8'hC8;
      IW'(14): code = 8'hDA;
      IW'(15): code = 8'h12;
      IW'(16): code = 8'h81;
      IW'(17): code = 8'hCF;
      IW'(18): code = 8'hD9;
      IW'(19): code = 8'hF1;
      IW'(20): code = 8'hDB;
      IW'(21): code = 8'h40;
      IW'(22): code = 8'hA4;
      IW'(23): code = 8'hA6;
      IW'(24): code = 8'hAF;
      // repaint window: columns then pages
      IW'(25): code = 8'h21;
      IW'(26): code = 8'h00;
      IW'(27): code = 8'(COLS - 1);
      IW'(28): code = 8'h22;
      IW'(29): code = 8'h00;
      IW'(30): code = 8'(PAGES - 1);
      default: code = 8'h00;
    endcase
  end
endmodule

// File: rtl/prc_req_latch.sv
module prc_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (take) pend <= 1'b0;
    else if (req)  pend <= 1'b1;
  end
endmodule

// File: rtl/panel_refresh_ctrl.sv
module panel_refresh_ctrl #(
  parameter int CYC_PER_MS = 100000,
  parameter int RST_MS     = 10,
  parameter int COLS       = 128,
  parameter int PAGES      = 8,
  parameter int AW         = $clog2(COLS * PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_req,
  input  logic          spi_busy,
  input  logic [7:0]    mem_rdata,
  output logic          spi_start,
  output logic [7:0]    spi_byte,
  output logic [AW-1:0] mem_addr,
  output logic          pnl_rst_n,
  output logic          pnl_dc,
  output logic          pnl_cs_n,
  output logic          flush_done
);
  import prc_pkg::*;

  localparam int FRAME = COLS * PAGES;
  localparam int CMD_N = INIT_LEN + WIN_LEN;
  localparam int CW    = $clog2(CMD_N);

  seq_state_t    st;
  logic [CW-1:0] cmd_idx;
  logic [7:0]    rom_code;
  logic          tmr_en, tmr_exp;
  logic          pend, take;

  assign tmr_en = (st == S_RLOW) || (st == S_RWAIT);
  assign take   = (st == S_IDLE);

  prc_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS(RST_MS)) u_tmr (
    .clk(clk), .rst(rst), .en(tmr_en), .expired(tmr_exp)
  );

  prc_cmd_rom #(.COLS(COLS), .PAGES(PAGES), .IW(CW)) u_rom (
    .idx(cmd_idx), .code(rom_code)
  );

  prc_req_latch u_req (
    .clk(clk), .rst(rst), .req(flush_req), .take(take), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_RLOW;
      cmd_idx    <= '0;
      spi_start  <= 1'b0;
      spi_byte   <= '0;
      mem_addr   <= '0;
      pnl_rst_n  <= 1'b0;
      pnl_dc     <= 1'b0;
      pnl_cs_n   <= 1'b1;
      flush_done <= 1'b0;
    end else begin
      spi_start  <= 1'b0;
      flush_done <= 1'b0;
      case (st)
        S_RLOW: if (tmr_exp) begin
          pnl_rst_n <= 1'b1;
          st        <= S_RWAIT;
        end
        S_RWAIT: if (tmr_exp) st <= S_CSEL;
        S_CSEL: begin
          pnl_cs_n  <= 1'b0;
          pnl_dc    <= 1'b0;
          spi_byte  <= rom_code;
          spi_start <= 1'b1;
          st        <= S_CHOLD;
        end
        S_CHOLD: st <= S_CWAIT;
        S_CWAIT: if (!spi_busy) begin
          pnl_cs_n <= 1'b1;
          cmd_idx  <= cmd_idx + 1'b1;
          if (cmd_idx == CW'(INIT_LEN - 1))   st <= S_IDLE;
          else if (cmd_idx == CW'(CMD_N - 1)) st <= S_DOPEN;
          else                                st <= S_CSEL;
        end
        S_IDLE: if (pend || flush_req) begin
          cmd_idx <= CW'(INIT_LEN);
          st      <= S_CSEL;
        end
        S_DOPEN: begin
          pnl_cs_n <= 1'b0;
          pnl_dc   <= 1'b1;
          mem_addr <= '0;
          st       <= S_DRD;
        end
        S_DRD: st <= S_DGO;
        S_DGO: begin
          spi_byte  <= mem_rdata;
          spi_start <= 1'b1;
          st        <= S_DHOLD;
        end
        S_DHOLD: st <= S_DWAIT;
        S_DWAIT: if (!spi_busy) begin
          if (mem_addr == AW'(FRAME - 1)) begin
            pnl_cs_n <= 1'b1;
            st       <= S_FIN;
          end else begin
            mem_addr <= mem_addr + 1'b1;
            st       <= S_DRD;
          end
        end
        S_FIN: begin
          flush_done <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_RLOW;
      endcase
    end
  end
endmodule

// File: rtl/panel_refresh_ctrl_chk.sv
module panel_refresh_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic spi_busy,
  input logic spi_start,
  input logic pnl_rst_n,
  input logic pnl_dc,
  input logic pnl_cs_n,
  input logic flush_done
);
  // R3: a start never lands on a busy shifter
  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> !spi_busy);
  // R3: start is a single-cycle pulse
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
    spi_start |=> !spi_start);
  // R5: every byte goes out inside a chip-select frame
  a_r5_start_in_frame: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> !pnl_cs_n);
  // R2: no traffic while the panel is held in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    !pnl_rst_n |-> (pnl_cs_n && !spi_start));
  // R6: data/command select does not move inside a frame
  a_r6_dc_steady: assert property (@(posedge clk) disable iff (rst)
    (!pnl_cs_n && $past(!pnl_cs_n)) |-> $stable(pnl_dc));
  // R8: done only with chip select released, and only for one cycle
  a_r8_done_cs_high: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> pnl_cs_n);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);
endmodule

bind panel_refresh_ctrl panel_refresh_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_start(spi_start),
  .pnl_rst_n(pnl_rst_n), .pnl_dc(pnl_dc), .pnl_cs_n(pnl_cs_n),
  .flush_done(flush_done)
);

// File: tb/panel_refresh_ctrl_test.sv
module panel_refresh_ctrl_test;
  localparam int CPM   = 20;
  localparam int RMS   = 10;
  localparam int LIM   = CPM * RMS;
  localparam int COLS  = 128;
  localparam int PAGES = 8;
  localparam int FRAME = COLS * PAGES;
  localparam int AW    = $clog2(FRAME);
  localparam int LOGN  = 2200;
  localparam int XFER  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_req = 1'b0;
  logic spi_busy = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic spi_start, pnl_rst_n, pnl_dc, pnl_cs_n, flush_done;
  logic [7:0] spi_byte;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  panel_refresh_ctrl #(.CYC_PER_MS(CPM), .RST_MS(RMS), .COLS(COLS), .PAGES(PAGES)) uut (
    .clk(clk), .rst(rst), .flush_req(flush_req), .spi_busy(spi_busy),
    .mem_rdata(mem_rdata), .spi_start(spi_start), .spi_byte(spi_byte),
    .mem_addr(mem_addr), .pnl_rst_n(pnl_rst_n), .pnl_dc(pnl_dc),
    .pnl_cs_n(pnl_cs_n), .flush_done(flush_done)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + (a >> 7) * 3 + 5) & 255);
  endfunction

  // frame memory model, one cycle read latency
  always @(posedge clk) mem_rdata <= pat(int'(mem_addr));

  // shifter model
  int sh_cnt = 0;
  always @(posedge clk) begin
    if (spi_start) begin
      spi_busy <= 1'b1;
      sh_cnt   <= XFER;
    end else if (spi_busy) begin
      sh_cnt <= sh_cnt - 1;
      if (sh_cnt == 1) spi_busy <= 1'b0;
    end
  end

  // monitor
  logic [7:0] log_b  [LOGN];
  logic       log_dc [LOGN];
  int log_n = 0, cs_falls = 0, done_cnt = 0, bad_done = 0;
  int rst_low_cyc = 0, gap_cyc = 0, cyc = 0;
  logic prev_cs = 1'b1, seen_cmd = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (spi_start) begin
      if (log_n < LOGN) begin
        log_b[log_n]  = spi_byte;
        log_dc[log_n] = pnl_dc;
      end
      log_n++;
    end
    if (prev_cs && !pnl_cs_n) begin
      cs_falls++;
      seen_cmd = 1'b1;
    end
    prev_cs = pnl_cs_n;
    if (flush_done) begin
      done_cnt++;
      if (pnl_cs_n !== 1'b1) bad_done++;
    end
    if (!rst && !pnl_rst_n) rst_low_cyc++;
    if (!rst && pnl_rst_n && !seen_cmd) gap_cyc++;
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic pulse_req();
    @(posedge clk); #2 flush_req = 1'b1;
    @(posedge clk); #2 flush_req = 1'b0;
  endtask

  task automatic clear_log();
    log_n = 0; cs_falls = 0; done_cnt = 0; bad_done = 0;
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 60000 && done_cnt < n; i++) tick(1);
  endtask

  task automatic check_flush(input int base, input string tag);
    logic [7:0] win [6] = '{8'h21, 8'h00, 8'(COLS-1), 8'h22, 8'h00, 8'(PAGES-1)};
    int bad_w = 0, bad_d = 0, first = -1;
    for (int i = 0; i < 6; i++)
      if (log_b[base+i] !== win[i] || log_dc[base+i] !== 1'b0) bad_w++;
    for (int a = 0; a < FRAME; a++)
      if (log_b[base+6+a] !== pat(a) || log_dc[base+6+a] !== 1'b1) begin
        bad_d++;
        if (first < 0) first = a;
      end
    chk(bad_w == 0, {"R6 window commands ", tag}, bad_w, 0);
    chk(bad_d == 0, {"R7 pixel bytes ", tag}, first, -1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(4);
    chk(pnl_rst_n == 1'b0 && pnl_cs_n == 1'b1 && !spi_start && !flush_done,
        "R1 reset outputs", {pnl_rst_n, pnl_cs_n, spi_start, flush_done}, 4'b0100);
    @(posedge clk); #2 rst = 1'b0;
    tick(1);
    chk(pnl_rst_n == 1'b0 && pnl_cs_n == 1'b1, "R1 first cycle out of reset",
        {pnl_rst_n, pnl_cs_n}, 2'b01);
  endtask

  task automatic t_init_with_early_req();
    tick(20);
    pulse_req();            // R9: arrives while panel reset is held
    wait_done(1);
    chk(rst_low_cyc >= LIM && rst_low_cyc <= LIM + 2, "R2 reset low length", rst_low_cyc, LIM);
    chk(gap_cyc >= LIM && gap_cyc <= LIM + 3, "R2 wait before first command", gap_cyc, LIM);
    begin
      logic [7:0] il [25] = '{8'hAE,8'hD5,8'h80,8'hA8,8'h3F,8'hD3,8'h00,8'h40,8'h8D,
                              8'h14,8'h20,8'h00,8'hA1,8'hC8,8'hDA,8'h12,8'h81,8'hCF,
                              8'hD9,8'hF1,8'hDB,8'h40,8'hA4,8'hA6,8'hAF};
      int bad = 0, first = -1;
      for (int i = 0; i < 25; i++)
        if (log_b[i] !== il[i] || log_dc[i] !== 1'b0) begin
          bad++;
          if (first < 0) first = i;
        end
      chk(bad == 0, "R4 configuration list", first, -1);
    end
    chk(done_cnt == 1, "R9 early request served", done_cnt, 1);
    chk(log_n == 25 + 6 + FRAME, "R9 byte count init plus flush", log_n, 25 + 6 + FRAME);
    chk(cs_falls == 25 + 6 + 1, "R5 one frame per command", cs_falls, 32);
    check_flush(25, "after init");
    chk(bad_done == 0, "R8 done with cs high", bad_done, 0);
  endtask

  task automatic t_idle();
    clear_log();
    tick(400);
    chk(log_n == 0 && cs_falls == 0 && done_cnt == 0, "R11 idle is quiet",
        log_n + cs_falls + done_cnt, 0);
  endtask

  task automatic t_single();
    clear_log();
    pulse_req();
    wait_done(1);
    tick(2);
    chk(done_cnt == 1, "R8 one done per flush", done_cnt, 1);
    chk(bad_done == 0, "R8 done after cs release", bad_done, 0);
    chk(cs_falls == 7, "R6 single frame for pixel burst", cs_falls, 7);
    chk(log_n == 6 + FRAME, "R6 flush byte count", log_n, 6 + FRAME);
    check_flush(0, "single");
    chk(pnl_cs_n == 1'b1 && !spi_start, "R3 quiet after flush", {pnl_cs_n, spi_start}, 2'b10);
  endtask

  task automatic t_during_flush();
    clear_log();
    pulse_req();
    tick(300);
    pulse_req();
    tick(50);
    pulse_req();            // R10: several requests mid-flush
    wait_done(2);
    tick(3000);
    chk(done_cnt == 2, "R10 exactly one extra flush", done_cnt, 2);
    chk(log_n == 2 * (6 + FRAME), "R10 byte count", log_n, 2 * (6 + FRAME));
    chk(cs_falls == 14, "R10 frame count", cs_falls, 14);
    check_flush(0, "first of pair");
    check_flush(6 + FRAME, "second of pair");
  endtask

  initial begin
    t_reset();
    t_init_with_early_req();
    t_idle();
    t_single();
    t_during_flush();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule